// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one DMA channel. Software sets it up through a small word-addressed register port, then sets the enable bit. The channel then copies a programmed number of elements from a source address to a destination address. It uses a single-beat valid/ready bus master port. Each element is a read followed by a write. Either side may walk through memory or stay on one fixed address, for example a peripheral data register.

Elements can run back to back for memory-to-memory copies. They can also be paced by a request line from a peripheral. Paced operation has two forms: one element per request, or the whole count started by a single request. The channel raises sticky flags for half-way, completion and bus error, and each flag can be routed to one interrupt output. A circular mode reloads the start addresses and count at the end of each pass, so the channel keeps streaming until software stops it.

Top module: `xfr_chan`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `bus_valid` is low. The register indices are:
  - 0: source address.
  - 1: destination address.
  - 2: count (low 16 bits).
  - 3: control.
  - 4: status.
  - 5: current source (read only).
  - 6: current destination (read only).
  - 7: remaining count (read only).
- R2: The control register fields are:
  - bit 0: enable.
  - bits 2:1: width code.
  - bit 3: source increment.
  - bit 4: destination increment.
  - bit 5: paced.
  - bits 7:6: mode (0 single, 1 block, 2 circular).
  - bits 10:8: interrupt enables for half (bit 8), done (bit 9) and error (bit 10).

  Writes to indices 0 to 3 take effect only while the channel is disabled and idle. While it is enabled, such writes are ignored, except that a control write with bit 0 clear disables the channel.
- R3: Each element is one source read followed by one destination write, and the write data equals the read data. `bus_valid`, `bus_addr` and `bus_write` hold steady until `bus_ready`. No new element starts before the write is accepted.
- R4: Width code 0, 1 or 2 moves 1, 2 or 4 bytes, and `bus_size` shows that code. A side whose increment bit is set advances by the element size after each element. A side whose bit is clear keeps the same address.
- R5: With paced set in single or circular mode, one element moves for each cycle in which `per_req` is seen high while the channel is waiting. No element moves without a request. With paced clear, elements move back to back.
- R6: With paced set in block mode, one request starts the whole programmed count.
- R7: The remaining count drops by one per element and the transfer ends when it reaches zero. In single and block modes, the enable bit then clears itself.
- R8: In circular mode, reaching zero reloads the start addresses and count, the transfer continues, and the enable bit stays set.
- R9: Status bit 0 (half) is set when floor(count/2) elements of a pass have moved, for counts of 2 or more. Status bit 1 (done) is set when a pass ends.
- R10: A bus error sets status bit 2, aborts the channel, clears the enable bit and stops all bus traffic. The failed element is not counted in the remaining count.
- R11: Status flags are sticky and cleared only by writing 1 to their bit at index 4. `irq` is the OR of each flag ANDed with its enable bit.
- R12: Enabling with a count of zero sets the done flag and clears the enable bit without any bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| per_req | input | 1 | Peripheral request |
| bus_valid | output | 1 | Bus transaction valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Bus byte address |
| bus_size | output | 2 | Element width code |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Transaction accepted this cycle |
| bus_err | input | 1 | Error response, valid with `bus_ready` |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps random `bus_ready` stalls running throughout. These stalls would catch a design that drops `bus_valid` or advances its address before acceptance: such a design writes wrong data or the wrong number of elements.

Directed cases target several specific failures:
- A paced channel left without requests must not move anything; a design that ignored pacing would move data anyway.
- A zero count must finish with no bus cycle; a design that skipped this check would underflow and run for ages.
- A circular pass must wrap back to its first address; a design that forgot the reload would run off the buffer end.
- An injected read error must leave exactly the earlier elements written; a design that failed to abort would keep writing.

Config-lock writes while enabled, and partial write-1-to-clear, confirm that a design which let these writes through would show changed readback.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int REG_W  = 32;

    localparam logic [2:0] RI_SRC  = 3'd0;
    localparam logic [2:0] RI_DST  = 3'd1;
    localparam logic [2:0] RI_CNT  = 3'd2;
    localparam logic [2:0] RI_CTRL = 3'd3;
    localparam logic [2:0] RI_STAT = 3'd4;
    localparam logic [2:0] RI_CSRC = 3'd5;
    localparam logic [2:0] RI_CDST = 3'd6;
    localparam logic [2:0] RI_REM  = 3'd7;

    localparam int NFLAG = 3;

    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_BLOCK  = 2'd1,
        MD_CIRC   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE, S_WAIT, S_RD, S_WR
    } eng_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  count;
        logic [1:0]        width;
        logic              src_inc;
        logic              dst_inc;
        logic              paced;
        logic [1:0]        mode;
        logic [NFLAG-1:0]  ie;
    } cfg_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_code(input logic [1:0] w);
        return (w == 2'd3) ? 2'd2 : w;
    endfunction
endpackage

// File: rtl/xfr_regs.sv
module xfr_regs
    import xfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              ev_half,
    input  logic              ev_done,
    input  logic              ev_err,
    input  logic              ev_stop,
    input  logic              eng_idle,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic [CNT_W-1:0]  remain,
    output cfg_t              cfg,
    output logic              en,
    output logic              start,
    output logic              irq
);
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] w1c;
    logic [REG_W-1:0] ctrl_rd;

    assign w1c = (cfg_we && cfg_addr == RI_STAT) ? cfg_wdata[NFLAG-1:0] : '0;
    assign irq = |(flags & cfg.ie);
    assign ctrl_rd = REG_W'({cfg.ie, cfg.mode, cfg.paced, cfg.dst_inc,
                             cfg.src_inc, cfg.width, en});

    always_comb begin
        case (cfg_addr)
            RI_SRC:  cfg_rdata = REG_W'(cfg.src);
            RI_DST:  cfg_rdata = REG_W'(cfg.dst);
            RI_CNT:  cfg_rdata = REG_W'(cfg.count);
            RI_CTRL: cfg_rdata = ctrl_rd;
            RI_STAT: cfg_rdata = REG_W'(flags);
            RI_CSRC: cfg_rdata = REG_W'(cur_src);
            RI_CDST: cfg_rdata = REG_W'(cur_dst);
            default: cfg_rdata = REG_W'(remain);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            en    <= 1'b0;
            start <= 1'b0;
            flags <= '0;
        end else begin
            start <= 1'b0;
            if (cfg_we && !en && eng_idle) begin
                case (cfg_addr)
                    RI_SRC: cfg.src   <= cfg_wdata[ADDR_W-1:0];
                    RI_DST: cfg.dst   <= cfg_wdata[ADDR_W-1:0];
                    RI_CNT: cfg.count <= cfg_wdata[CNT_W-1:0];
                    RI_CTRL: begin
                        cfg.width   <= cfg_wdata[2:1];
                        cfg.src_inc <= cfg_wdata[3];
                        cfg.dst_inc <= cfg_wdata[4];
                        cfg.paced   <= cfg_wdata[5];
                        cfg.mode    <= cfg_wdata[7:6];
                        cfg.ie      <= cfg_wdata[10:8];
                        en          <= cfg_wdata[0];
                        start       <= cfg_wdata[0];
                    end
                    default: ;
                endcase
            end else if (cfg_we && en && cfg_addr == RI_CTRL && !cfg_wdata[0]) begin
                en <= 1'b0;
            end
            if (ev_stop) en <= 1'b0;
            flags <= (flags & ~w1c) | {ev_err, ev_done, ev_half};
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(cfg)); // R2
    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> !en); // R7
endmodule

// File: rtl/xfr_engine.sv
module xfr_engine
    import xfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              en,
    input  logic              start,
    input  logic              per_req,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              ev_half,
    output logic              ev_done,
    output logic              ev_err,
    output logic              ev_stop,
    output logic              eng_idle,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  remain
);
    eng_state_e        st;
    logic [DATA_W-1:0] data_q;
    logic              acc, ok_wr, last, zero_go, circ;
    logic [CNT_W-1:0]  rem_nx;
    logic [ADDR_W-1:0] step;

    always_comb begin
        bus_valid = (st == S_RD) || (st == S_WR);
        bus_write = (st == S_WR);
        bus_addr  = (st == S_WR) ? cur_dst : cur_src;
        bus_size  = size_code(cfg.width);
        bus_wdata = data_q;
        eng_idle  = (st == S_IDLE);
        circ      = (cfg.mode == MD_CIRC);
        step      = ADDR_W'(elem_bytes(cfg.width));
        acc       = bus_valid && bus_ready;
        ok_wr     = (st == S_WR) && acc && !bus_err;
        rem_nx    = remain - 1'b1;
        last      = (rem_nx == '0);
        zero_go   = (st == S_IDLE) && start && (cfg.count == '0);
        ev_err    = acc && bus_err;
        ev_done   = zero_go || (ok_wr && last);
        ev_half   = ok_wr && (cfg.count >= CNT_W'(2))
                    && (rem_nx == cfg.count - (cfg.count >> 1));
        ev_stop   = ev_err || zero_go || (ok_wr && last && !circ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            data_q  <= '0;
            cur_src <= '0;
            cur_dst <= '0;
            remain  <= '0;
        end else begin
            case (st)
                S_IDLE: if (start && cfg.count != '0) begin
                    cur_src <= cfg.src;
                    cur_dst <= cfg.dst;
                    remain  <= cfg.count;
                    st      <= cfg.paced ? S_WAIT : S_RD;
                end
                S_WAIT: begin
                    if (!en)          st <= S_IDLE;
                    else if (per_req) st <= S_RD;
                end
                S_RD: if (acc) begin
                    if (bus_err) st <= S_IDLE;
                    else begin
                        data_q <= bus_rdata;
                        st     <= S_WR;
                    end
                end
                default: if (acc) begin
                    if (bus_err) st <= S_IDLE;
                    else begin
                        remain <= rem_nx;
                        if (cfg.src_inc) cur_src <= cur_src + step;
                        if (cfg.dst_inc) cur_dst <= cur_dst + step;
                        if (last) begin
                            if (circ && en) begin
                                cur_src <= cfg.src;
                                cur_dst <= cfg.dst;
                                remain  <= cfg.count;
                                st      <= cfg.paced ? S_WAIT : S_RD;
                            end else begin
                                st <= S_IDLE;
                            end
                        end else if (!en) begin
                            st <= S_IDLE;
                        end else begin
                            st <= (cfg.paced && cfg.mode != MD_BLOCK) ? S_WAIT : S_RD;
                        end
                    end
                end
            endcase
        end
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write)); // R3
    AST_WAIT_GATE: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT) && !per_req |=> !bus_valid); // R5
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
        ev_err |=> !bus_valid); // R10
    AST_ZERO_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        zero_go |=> !bus_valid); // R12
endmodule

// File: rtl/xfr_chan.sv
module xfr_chan
    import xfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              per_req,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    cfg_t              cfg;
    logic              en, start, eng_idle;
    logic              ev_half, ev_done, ev_err, ev_stop;
    logic [ADDR_W-1:0] cur_src, cur_dst;
    logic [CNT_W-1:0]  remain;

    xfr_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ev_half(ev_half), .ev_done(ev_done), .ev_err(ev_err), .ev_stop(ev_stop),
        .eng_idle(eng_idle), .cur_src(cur_src), .cur_dst(cur_dst), .remain(remain),
        .cfg(cfg), .en(en), .start(start), .irq(irq)
    );

    xfr_engine u_eng (
        .clk(clk), .rst(rst), .cfg(cfg), .en(en), .start(start), .per_req(per_req),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata),
        .ev_half(ev_half), .ev_done(ev_done), .ev_err(ev_err), .ev_stop(ev_stop),
        .eng_idle(eng_idle), .cur_src(cur_src), .cur_dst(cur_dst), .remain(remain)
    );
endmodule

// File: tb/xfr_chan_tb_top.sv
module xfr_chan_tb_top;
    import xfr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        per_req = 1'b0;
    logic        bus_valid, bus_write, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_ready = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    xfr_chan dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    logic        err_arm = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] lg_addr [256];
    logic [31:0] lg_data [256];
    logic [1:0]  lg_size [256];
    int wlog_n = 0;
    int vcnt = 0;

    function automatic logic [31:0] memv(input logic [31:0] a);
        return {a[15:0] ^ 16'hC35A, a[15:0] + 16'h1234};
    endfunction

    // Memory model: decides ready at the negative edge, logs accepted writes.
    always @(negedge clk) begin
        bus_ready <= 1'b0;
        bus_err   <= 1'b0;
        if (bus_valid) vcnt <= vcnt + 1;
        if (bus_valid && ($urandom % 3 != 0)) begin
            bus_ready <= 1'b1;
            bus_rdata <= memv(bus_addr);
            bus_err   <= err_arm && !bus_write && bus_addr == err_addr;
            if (bus_write) begin
                lg_addr[wlog_n % 256] <= bus_addr;
                lg_data[wlog_n % 256] <= bus_wdata;
                lg_size[wlog_n % 256] <= bus_size;
                wlog_n <= wlog_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse_req();
        @(negedge clk); per_req = 1'b1;
        @(negedge clk); per_req = 1'b0;
    endtask

    task automatic wait_flag(input int bitn);
        logic [31:0] s;
        for (int k = 0; k < 3000; k++) begin
            rd(RI_STAT, s);
            if (s[bitn]) break;
        end
    endtask

    function automatic logic [31:0] ctrlw(input logic [1:0] w, input bit si, input bit di,
                                          input bit pc, input logic [1:0] md, input logic [2:0] ie);
        return {21'd0, ie, md, pc, di, si, w, 1'b1};
    endfunction

    task automatic run_xfer(input logic [31:0] src, input logic [31:0] dst, input int cnt,
                            input logic [1:0] w, input bit si, input bit di,
                            input bit pc, input logic [1:0] md);
        logic [31:0] v;
        int base, miss, nb;
        logic [31:0] ea;
        nb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        wr(RI_STAT, 32'h7);
        wr(RI_SRC, src); wr(RI_DST, dst); wr(RI_CNT, cnt);
        base = wlog_n;
        wr(RI_CTRL, ctrlw(w, si, di, pc, md, 3'b000));
        if (pc) begin
            repeat (10) @(negedge clk);
            chk(wlog_n == base, "R5 no element without request", wlog_n - base, 0);
            if (md == MD_BLOCK) pulse_req();   // R6 one request, full count
            else begin
                for (int i = 0; i < cnt; i++) begin
                    pulse_req();
                    for (int k = 0; k < 200 && wlog_n < base + i + 1; k++) @(negedge clk);
                    repeat (2) @(negedge clk);
                end
            end
        end
        wait_flag(1);
        repeat (2) @(negedge clk);
        chk(wlog_n - base == cnt, "R3 element count", wlog_n - base, cnt);
        miss = 0;
        for (int i = 0; i < cnt; i++) begin
            ea = src + (si ? i * nb : 0);
            if (lg_addr[(base + i) % 256] != dst + (di ? i * nb : 0)) miss++;
            if (lg_data[(base + i) % 256] != memv(ea)) miss++;
            if (lg_size[(base + i) % 256] != w) miss++;
        end
        chk(miss == 0, "R4 address/data/size per element", miss, 0);
        rd(RI_REM, v);  chk(v == 0, "R7 remaining zero", v, 0);
        rd(RI_CTRL, v); chk(v[0] == 0, "R7 enable self-clears", v[0], 0);
        rd(RI_STAT, v); chk(v[0] == (cnt >= 2), "R9 half flag", v[0], cnt >= 2);
        rd(RI_CSRC, v); chk(v == src + (si ? cnt * nb : 0), "R4 final source", v, src + (si ? cnt * nb : 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, old;
        int n0, n1, base, miss, rs;
        rs = $urandom(1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!irq, "R1 irq low", irq, 0);
        chk(!bus_valid, "R1 bus idle", bus_valid, 0);
        rd(RI_CTRL, v); chk(v == 0, "R1 control zero", v, 0);
        rd(RI_STAT, v); chk(v == 0, "R1 status zero", v, 0);
        rd(RI_REM, v);  chk(v == 0, "R1 remaining zero", v, 0);

        // directed transfers
        run_xfer(32'h1000, 32'h2000, 5, 2'd2, 1, 1, 0, MD_SINGLE);
        run_xfer(32'h0040, 32'h3000, 4, 2'd0, 0, 1, 1, MD_SINGLE);
        run_xfer(32'h5000, 32'h0080, 6, 2'd1, 1, 0, 1, MD_BLOCK);
        run_xfer(32'h6000, 32'h7000, 1, 2'd2, 1, 1, 0, MD_BLOCK);

        // R2 config lock while enabled
        wr(RI_STAT, 32'h7);
        wr(RI_SRC, 32'h0000_8000); wr(RI_DST, 32'h0000_9000); wr(RI_CNT, 2);
        wr(RI_CTRL, ctrlw(2'd2, 1, 1, 1, MD_SINGLE, 3'b000));
        wr(RI_SRC, 32'h0000_ABC0);
        rd(RI_SRC, v); chk(v == 32'h8000, "R2 source locked", v, 32'h8000);
        wr(RI_CTRL, ctrlw(2'd0, 0, 0, 0, MD_CIRC, 3'b111));
        rd(RI_CTRL, old);
        chk(old == ctrlw(2'd2, 1, 1, 1, MD_SINGLE, 3'b000), "R2 control locked", old,
            ctrlw(2'd2, 1, 1, 1, MD_SINGLE, 3'b000));
        wr(RI_CTRL, 32'h0);
        rd(RI_CTRL, v); chk(v[0] == 0, "R2 disable accepted", v[0], 0);
        n0 = wlog_n;
        pulse_req(); repeat (10) @(negedge clk);
        chk(wlog_n == n0, "R2 disabled channel ignores request", wlog_n - n0, 0);

        // R12 zero count with done interrupt
        wr(RI_STAT, 32'h7);
        wr(RI_CNT, 0);
        n0 = vcnt;
        wr(RI_CTRL, ctrlw(2'd2, 1, 1, 0, MD_CIRC, 3'b010));
        repeat (5) @(negedge clk);
        rd(RI_STAT, v); chk(v[1] == 1, "R12 done on zero count", v, 32'h2);
        chk(vcnt == n0, "R12 no bus cycles", vcnt - n0, 0);
        rd(RI_CTRL, v); chk(v[0] == 0, "R12 enable cleared", v[0], 0);
        chk(irq == 1, "R11 irq from done enable", irq, 1);
        wr(RI_STAT, 32'h2);
        @(negedge clk); chk(irq == 0, "R11 irq drops after clear", irq, 0);

        // R8 circular streaming
        wr(RI_SRC, 32'h0000_1100); wr(RI_DST, 32'h0000_2200); wr(RI_CNT, 3);
        base = wlog_n;
        wr(RI_CTRL, ctrlw(2'd2, 1, 1, 0, MD_CIRC, 3'b000));
        for (int k = 0; k < 2000 && wlog_n < base + 8; k++) @(negedge clk);
        rd(RI_CTRL, v); chk(v[0] == 1, "R8 enable stays set", v[0], 1);
        rd(RI_STAT, v); chk(v[1:0] == 2'b11, "R9 half and done in circular", v[1:0], 3);
        wr(RI_CTRL, 32'h0);
        repeat (10) @(negedge clk);
        n1 = wlog_n;
        repeat (10) @(negedge clk);
        chk(wlog_n == n1, "R8 stops after disable", wlog_n - n1, 0);
        miss = 0;
        for (int i = 0; i < n1 - base; i++) begin
            if (lg_addr[(base + i) % 256] != 32'h2200 + (i % 3) * 4) miss++;
            if (lg_data[(base + i) % 256] != memv(32'h1100 + (i % 3) * 4)) miss++;
        end
        chk(miss == 0 && n1 - base >= 8, "R8 wrap to start", miss, 0);

        // R11 partial write-1-to-clear
        wr(RI_STAT, 32'h1);
        rd(RI_STAT, v); chk(v[2:0] == 3'b010, "R11 only written bit clears", v, 2);
        wr(RI_STAT, 32'h7);

        // R10 bus error on third source read
        err_arm = 1'b1; err_addr = 32'h0000_3008;
        wr(RI_SRC, 32'h0000_3000); wr(RI_DST, 32'h0000_4000); wr(RI_CNT, 5);
        base = wlog_n;
        wr(RI_CTRL, ctrlw(2'd2, 1, 1, 0, MD_SINGLE, 3'b100));
        wait_flag(2);
        repeat (2) @(negedge clk);
        n0 = vcnt;
        repeat (10) @(negedge clk);
        chk(vcnt == n0, "R10 bus quiet after error", vcnt - n0, 0);
        chk(wlog_n - base == 2, "R10 writes before abort", wlog_n - base, 2);
        rd(RI_CTRL, v); chk(v[0] == 0, "R10 enable cleared", v[0], 0);
        rd(RI_REM, v);  chk(v == 3, "R10 remaining excludes failed element", v, 3);
        chk(irq == 1, "R11 irq from error enable", irq, 1);
        err_arm = 1'b0;
        wr(RI_STAT, 32'h7);

        // random transfers
        for (int t = 0; t < 8; t++) begin
            logic [1:0] w;
            w = 2'($urandom % 3);
            run_xfer(32'h0001_0000 + ($urandom % 64) * 4, 32'h0002_0000 + ($urandom % 64) * 4,
                     1 + $urandom % 9, w, 1'($urandom % 2), 1'($urandom % 2),
                     1'($urandom % 2), 2'($urandom % 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule